// File: doc/BRIEF.md
# DRAM Command Timing Gate

This block sits on one memory channel, between the command scheduler and the memory pins. The scheduler offers one command per cycle: an opcode (activate, read, write, precharge or auto-refresh) and a bank number. The block decides whether that command may go out in this cycle without breaking a programmed DRAM timing rule. If the command is allowed, it passes straight through to the issue outputs. If it is not, ready stays low and the scheduler keeps the same command waiting.

The block holds its timing parameters in one 32-bit register, written through a simple write-enable port. It keeps countdown timers for each bank and for the whole device. Each timer loads when its qualifying command issues, counts down once per clock and stops at zero. The same-bank row cycle is handled differently. At activate, the block copies a read limit and a write limit for that bank, then tracks which one applies: a row becomes a "write row" as soon as any write reaches it. A build-time parameter picks where the write-to-read spacing comes from. It is either the programmed field or a value computed from the other timings.

All spacings are counted in issue cycles. A rule of N cycles means the second command can issue no earlier than N cycles after the first. A value of 0 or 1 therefore lets it issue on the very next cycle.

Top module: `dram_cmd_gate`

## Requirements
- R1: `issue_valid` is high exactly when `cmd_valid` and `cmd_ready` are both high, and then `issue_op`/`issue_bank` equal the offered command. Ops are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5; 6 and 7 are reserved. NOP, PRE and the reserved codes are always ready. A command held while not ready issues unchanged once it becomes ready.
- R2: A RD or WR to a bank issues no earlier than `cfg[3:0]` cycles after the ACT to that bank.
- R3: An ACT to a bank issues no earlier than `cfg[7:4]` cycles after a PRE to that bank.
- R4: An ACT issues no earlier than `cfg[11:8]` cycles after the most recent ACT, when that ACT went to a different bank.
- R5: An ACT to a bank issues no earlier than L+1 cycles after the previous ACT to that bank. L is `cfg[15:12]` if no WR reached the row, and `cfg[19:16]` if a WR did. Both values are sampled when the row was activated.
- R6: With the default build (`USE_DERIVED_WTR`=0), a RD to any bank issues no earlier than `cfg[23:20]` cycles after the last WR to any bank.
- R7: An ACT or REF issues no earlier than `cfg[27:24]` cycles after a REF. PRE is not blocked by this rule.
- R8: Reset loads the register with 0x1C4A9243, and every command is ready in the first cycle after reset.
- R9: A register write is seen by commands issued in later cycles only. Timers that are already counting keep their loaded values.
- R10: With `USE_DERIVED_WTR`=1, the write-to-read spacing is `cfg[19:16]`+1 − (`cfg[3:0]` + `cfg[31:28]` + 3), clamped to 0..15. Here `cfg[31:28]` is the write-data delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Timing register write enable |
| reg_wdata | input | 32 | Timing register write value |
| cmd_valid | input | 1 | Scheduler offers a command |
| cmd_op | input | 3 | Offered opcode |
| cmd_bank | input | BANK_W | Offered bank |
| cmd_ready | output | 1 | Offered command meets every timing rule |
| issue_valid | output | 1 | Command goes to the pins this cycle |
| issue_op | output | 3 | Issued opcode |
| issue_bank | output | BANK_W | Issued bank |

## Verification
The bound checker looks at every cycle for these early issues:
- a column command right after the activate to its bank,
- an activate right after a precharge to its bank,
- a cross-bank activate right after another activate,
- a read right after a write,
- an activate or refresh right after a refresh.

It also checks that nothing issues without a valid. These checks apply whenever the programmed spacing is two or more cycles. The exact spacing values can only be shown by the bench's directed scenarios. The same holds for the switch from read-row to write-row limits, for timers already counting that ignore a register write, for zero-valued fields, and for the derived write-to-read variant.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    localparam int FW       = 4;
    localparam int REG_W    = 32;
    localparam int NBANK_DEF = 8;

    localparam logic [2:0] OP_NOP = 3'd0;
    localparam logic [2:0] OP_ACT = 3'd1;
    localparam logic [2:0] OP_RD  = 3'd2;
    localparam logic [2:0] OP_WR  = 3'd3;
    localparam logic [2:0] OP_PRE = 3'd4;
    localparam logic [2:0] OP_REF = 3'd5;

    typedef struct packed {
        logic [FW-1:0] tcwd;       // [31:28]
        logic [FW-1:0] trfc;       // [27:24]
        logic [FW-1:0] twr2rd;     // [23:20]
        logic [FW-1:0] trc_wr_m1;  // [19:16]
        logic [FW-1:0] trc_rd_m1;  // [15:12]
        logic [FW-1:0] trrd;       // [11:8]
        logic [FW-1:0] trp;        // [7:4]
        logic [FW-1:0] trcd;       // [3:0]
    } tcfg_t;

    localparam tcfg_t CFG_RESET = tcfg_t'(32'h1C4A_9243);

    // Value a countdown loads so that a spacing of n cycles is met n cycles later.
    function automatic logic [FW-1:0] gap_load(input logic [FW-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    function automatic logic [FW-1:0] dec_sat(input logic [FW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    function automatic logic [FW-1:0] derive_wr2rd(input tcfg_t c);
        int v;
        v = int'(c.trc_wr_m1) + 1 - (int'(c.trcd) + int'(c.tcwd) + 3);
        if (v < 0) v = 0;
        if (v > (1 << FW) - 1) v = (1 << FW) - 1;
        return FW'(v);
    endfunction

endpackage

// File: rtl/dcg_cfg_reg.sv
module dcg_cfg_reg
    import dcg_pkg::*;
#(
    parameter bit USE_DERIVED_WTR = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output tcfg_t            cfg
);

    tcfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (we) begin
            cfg_q <= tcfg_t'(wdata);
        end
    end

    generate
        if (USE_DERIVED_WTR) begin : g_derived
            always_comb begin
                cfg        = cfg_q;
                cfg.twr2rd = derive_wr2rd(cfg_q);
            end
        end else begin : g_field
            always_comb cfg = cfg_q;
        end
    endgenerate

endmodule

// File: rtl/dcg_bank_timer.sv
module dcg_bank_timer
    import dcg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [FW-1:0] trcd,
    input  logic [FW-1:0] trp,
    input  logic [FW-1:0] trc_rd_m1,
    input  logic [FW-1:0] trc_wr_m1,
    input  logic          act_go,
    input  logic          wr_go,
    input  logic          pre_go,
    output logic          act_ok,
    output logic          col_ok
);

    localparam int AGE_W = FW + 1;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [FW-1:0]    rcd_q;
    logic [FW-1:0]    rp_q;
    logic [FW-1:0]    lim_rd_q;
    logic [FW-1:0]    lim_wr_q;
    logic [AGE_W-1:0] age_q;
    logic             wr_row_q;
    logic [AGE_W-1:0] need;

    always_ff @(posedge clk) begin
        if (rst) begin
            rcd_q    <= '0;
            rp_q     <= '0;
            lim_rd_q <= '0;
            lim_wr_q <= '0;
            age_q    <= AGE_MAX;
            wr_row_q <= 1'b0;
        end else begin
            rcd_q <= act_go ? gap_load(trcd) : dec_sat(rcd_q);
            rp_q  <= pre_go ? gap_load(trp)  : dec_sat(rp_q);
            if (act_go) begin
                age_q    <= AGE_W'(1);
                lim_rd_q <= trc_rd_m1;
                lim_wr_q <= trc_wr_m1;
                wr_row_q <= 1'b0;
            end else begin
                if (age_q != AGE_MAX) age_q <= age_q + 1'b1;
                if (wr_go) wr_row_q <= 1'b1;
            end
        end
    end

    always_comb begin
        need   = {1'b0, (wr_row_q ? lim_wr_q : lim_rd_q)} + 1'b1;
        act_ok = (rp_q == '0) && (age_q >= need);
        col_ok = (rcd_q == '0);
    end

endmodule

// File: rtl/dcg_dev_timer.sv
module dcg_dev_timer
    import dcg_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FW-1:0]     trrd,
    input  logic [FW-1:0]     twr2rd,
    input  logic [FW-1:0]     trfc,
    input  logic              act_go,
    input  logic              wr_go,
    input  logic              ref_go,
    input  logic [BANK_W-1:0] bank,
    output logic              act_ok,
    output logic              rd_ok,
    output logic              ref_ok
);

    logic [FW-1:0]     rrd_q;
    logic [FW-1:0]     wtr_q;
    logic [FW-1:0]     rfc_q;
    logic [BANK_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rrd_q  <= '0;
            wtr_q  <= '0;
            rfc_q  <= '0;
            last_q <= '0;
        end else begin
            rrd_q <= act_go ? gap_load(trrd)   : dec_sat(rrd_q);
            wtr_q <= wr_go  ? gap_load(twr2rd) : dec_sat(wtr_q);
            rfc_q <= ref_go ? gap_load(trfc)   : dec_sat(rfc_q);
            if (act_go) last_q <= bank;
        end
    end

    always_comb begin
        ref_ok = (rfc_q == '0);
        act_ok = ((rrd_q == '0) || (bank == last_q)) && ref_ok;
        rd_ok  = (wtr_q == '0);
    end

endmodule

// File: rtl/dram_cmd_gate.sv
module dram_cmd_gate
    import dcg_pkg::*;
#(
    parameter int  NBANK           = NBANK_DEF,
    parameter bit  USE_DERIVED_WTR = 1'b0,
    localparam int BANK_W          = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    output logic              cmd_ready,
    output logic              issue_valid,
    output logic [2:0]        issue_op,
    output logic [BANK_W-1:0] issue_bank
);

    tcfg_t cfg;
    logic [NBANK-1:0] bank_act_ok;
    logic [NBANK-1:0] bank_col_ok;
    logic dev_act_ok, dev_rd_ok, dev_ref_ok;
    logic go, go_act, go_wr, go_pre, go_ref;

    dcg_cfg_reg #(.USE_DERIVED_WTR(USE_DERIVED_WTR)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .wdata (reg_wdata),
        .cfg   (cfg)
    );

    assign go     = cmd_valid && cmd_ready;
    assign go_act = go && (cmd_op == OP_ACT);
    assign go_wr  = go && (cmd_op == OP_WR);
    assign go_pre = go && (cmd_op == OP_PRE);
    assign go_ref = go && (cmd_op == OP_REF);

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic sel;
            assign sel = (cmd_bank == BANK_W'(b));
            dcg_bank_timer u_bank (
                .clk       (clk),
                .rst       (rst),
                .trcd      (cfg.trcd),
                .trp       (cfg.trp),
                .trc_rd_m1 (cfg.trc_rd_m1),
                .trc_wr_m1 (cfg.trc_wr_m1),
                .act_go    (go_act && sel),
                .wr_go     (go_wr && sel),
                .pre_go    (go_pre && sel),
                .act_ok    (bank_act_ok[b]),
                .col_ok    (bank_col_ok[b])
            );
        end
    endgenerate

    dcg_dev_timer #(.BANK_W(BANK_W)) u_dev (
        .clk    (clk),
        .rst    (rst),
        .trrd   (cfg.trrd),
        .twr2rd (cfg.twr2rd),
        .trfc   (cfg.trfc),
        .act_go (go_act),
        .wr_go  (go_wr),
        .ref_go (go_ref),
        .bank   (cmd_bank),
        .act_ok (dev_act_ok),
        .rd_ok  (dev_rd_ok),
        .ref_ok (dev_ref_ok)
    );

    always_comb begin
        case (cmd_op)
            OP_ACT:  cmd_ready = bank_act_ok[cmd_bank] && dev_act_ok;
            OP_RD:   cmd_ready = bank_col_ok[cmd_bank] && dev_rd_ok;
            OP_WR:   cmd_ready = bank_col_ok[cmd_bank];
            OP_REF:  cmd_ready = dev_ref_ok;
            default: cmd_ready = 1'b1;
        endcase
    end

    assign issue_valid = go;
    assign issue_op    = cmd_op;
    assign issue_bank  = cmd_bank;

endmodule

// File: rtl/dcg_checker.sv
module dcg_checker
    import dcg_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              issue_valid,
    input logic [2:0]        issue_op,
    input logic [BANK_W-1:0] issue_bank,
    input tcfg_t             cfg
);

    logic is_act, is_col, is_rd, is_wr, is_pre, is_ref;
    assign is_act = issue_valid && (issue_op == OP_ACT);
    assign is_rd  = issue_valid && (issue_op == OP_RD);
    assign is_wr  = issue_valid && (issue_op == OP_WR);
    assign is_col = is_rd || is_wr;
    assign is_pre = issue_valid && (issue_op == OP_PRE);
    assign is_ref = issue_valid && (issue_op == OP_REF);

    AST_NO_ISSUE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> !issue_valid); // R1

    AST_RCD_GAP: assert property (@(posedge clk) disable iff (rst)
        (is_act && cfg.trcd >= 2) |=> !(is_col && issue_bank == $past(issue_bank))); // R2

    AST_RP_GAP: assert property (@(posedge clk) disable iff (rst)
        (is_pre && cfg.trp >= 2) |=> !(is_act && issue_bank == $past(issue_bank))); // R3

    AST_RRD_GAP: assert property (@(posedge clk) disable iff (rst)
        (is_act && cfg.trrd >= 2) |=> !(is_act && issue_bank != $past(issue_bank))); // R4

    AST_RC_GAP: assert property (@(posedge clk) disable iff (rst)
        (is_act && cfg.trc_rd_m1 >= 1 && cfg.trc_wr_m1 >= 1)
            |=> !(is_act && issue_bank == $past(issue_bank))); // R5

    AST_WTR_GAP: assert property (@(posedge clk) disable iff (rst)
        (is_wr && cfg.twr2rd >= 2) |=> !is_rd); // R6

    AST_RFC_GAP: assert property (@(posedge clk) disable iff (rst)
        (is_ref && cfg.trfc >= 2) |=> !(is_act || is_ref)); // R7

endmodule

bind dram_cmd_gate dcg_checker #(.BANK_W(BANK_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .issue_bank  (issue_bank),
    .cfg         (cfg)
);

// File: tb/dram_cmd_gate_test.sv
module dram_cmd_gate_test;
    import dcg_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = OP_NOP;
    logic [2:0]  cmd_bank = '0;
    logic        cmd_ready, issue_valid;
    logic [2:0]  issue_op, issue_bank;
    logic        cmd_ready2, issue_valid2;
    logic [2:0]  issue_op2, issue_bank2;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_cmd_gate uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_ready(cmd_ready), .issue_valid(issue_valid),
        .issue_op(issue_op), .issue_bank(issue_bank)
    );

    dram_cmd_gate #(.USE_DERIVED_WTR(1'b1)) uut2 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_ready(cmd_ready2), .issue_valid(issue_valid2),
        .issue_op(issue_op2), .issue_bank(issue_bank2)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = OP_NOP;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    // Offer a command, hold it until ready, return the cycle in which it issued.
    task automatic send(input logic [2:0] op, input int bank, input string req, output int at);
        int waits;
        waits = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank[2:0];
        #1;
        while (!cmd_ready && waits < 100) begin
            if (issue_valid) chk(1'b0, "R1 held command leaked", 1, 0);
            @(negedge clk); #1;
            waits++;
        end
        chk(cmd_ready, {req, " ready within window"}, waits, 99);
        chk(issue_valid && issue_op == op && issue_bank == bank[2:0],
            "R1 issue mirrors offered command", int'(issue_op), int'(op));
        at = cyc;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_op = OP_NOP;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = OP_ACT; cmd_bank = 3'd0; #1;
        chk(cmd_ready, "R8 ACT ready after reset", cmd_ready, 1);
        chk(!issue_valid, "R1 no issue without valid", issue_valid, 0);
        cmd_op = OP_REF; #1;
        chk(cmd_ready, "R8 REF ready after reset", cmd_ready, 1);
        cmd_op = OP_RD; #1;
        chk(cmd_ready, "R8 RD ready after reset", cmd_ready, 1);
        cmd_op = OP_NOP;
    endtask

    task automatic t_always_ready();
        int a, b;
        send(OP_ACT, 0, "R1", a);
        send(OP_PRE, 0, "R1", b);
        chk(b - a == 1, "R1 PRE never blocked", b - a, 1);
        @(negedge clk);
        cmd_op = 3'd7; #1;
        chk(cmd_ready, "R1 reserved op ready", cmd_ready, 1);
        cmd_op = OP_NOP; #1;
        chk(cmd_ready, "R1 NOP ready", cmd_ready, 1);
        idle(20);
    endtask

    task automatic t_rcd();
        int a, b;
        send(OP_ACT, 1, "R2", a);
        send(OP_RD, 1, "R2", b);
        chk(b - a == 3, "R2 ACT to RD spacing", b - a, 3);
        idle(20);
    endtask

    task automatic t_rp();
        int a, b;
        send(OP_PRE, 2, "R3", a);
        send(OP_ACT, 2, "R3", b);
        chk(b - a == 4, "R3 PRE to ACT spacing", b - a, 4);
        idle(20);
    endtask

    task automatic t_rrd();
        int a, b;
        send(OP_ACT, 3, "R4", a);
        send(OP_ACT, 0, "R4", b);
        chk(b - a == 2, "R4 ACT to ACT other bank", b - a, 2);
        idle(20);
    endtask

    task automatic t_rc();
        int a, c, d;
        send(OP_ACT, 4, "R5", a);
        send(OP_RD, 4, "R5", c);
        send(OP_PRE, 4, "R5", c);
        send(OP_ACT, 4, "R5", d);
        chk(d - a == 10, "R5 read row cycle", d - a, 10);
        idle(20);
        send(OP_ACT, 5, "R5", a);
        send(OP_WR, 5, "R5", c);
        send(OP_PRE, 5, "R5", c);
        send(OP_ACT, 5, "R5", d);
        chk(d - a == 11, "R5 write row cycle", d - a, 11);
        idle(20);
    endtask

    task automatic t_wtr();
        int a, w, r;
        send(OP_ACT, 6, "R6", a);
        send(OP_WR, 6, "R6", w);
        send(OP_RD, 6, "R6", r);
        chk(r - w == 4, "R6 WR to RD same bank", r - w, 4);
        idle(20);
        send(OP_ACT, 7, "R6", a);
        send(OP_WR, 7, "R6", w);
        send(OP_RD, 6, "R6", r);
        chk(r - w == 4, "R6 WR to RD other bank", r - w, 4);
        idle(20);
    endtask

    task automatic t_rfc();
        int a, b, c, p;
        send(OP_REF, 0, "R7", a);
        send(OP_PRE, 1, "R7", p);
        chk(p - a == 1, "R7 PRE not blocked by refresh", p - a, 1);
        send(OP_REF, 0, "R7", b);
        chk(b - a == 12, "R7 REF to REF", b - a, 12);
        send(OP_ACT, 1, "R7", c);
        chk(c - b == 12, "R7 REF to ACT", c - b, 12);
        idle(20);
    endtask

    task automatic t_reg_write();
        int a, b;
        wr_reg(32'h1C4A_9246);
        send(OP_ACT, 3, "R9", a);
        send(OP_RD, 3, "R9", b);
        chk(b - a == 6, "R9 new trcd applies", b - a, 6);
        idle(20);
        send(OP_ACT, 0, "R9", a);
        wr_reg(32'h1C4A_9241);
        send(OP_RD, 0, "R9", b);
        chk(b - a == 6, "R9 running timer kept", b - a, 6);
        idle(20);
        send(OP_ACT, 2, "R9", a);
        send(OP_RD, 2, "R9", b);
        chk(b - a == 1, "R9 trcd of one", b - a, 1);
        idle(20);
    endtask

    task automatic t_zero_fields();
        int a, w, r;
        wr_reg(32'h100A_9241);
        send(OP_ACT, 1, "R6", a);
        send(OP_WR, 1, "R6", w);
        send(OP_RD, 1, "R6", r);
        chk(r - w == 1, "R6 zero WR to RD spacing", r - w, 1);
        send(OP_REF, 0, "R7", a);
        send(OP_REF, 0, "R7", w);
        chk(w - a == 1, "R7 zero refresh recovery", w - a, 1);
        idle(20);
    endtask

    task automatic t_derived();
        int a, w, first1, first2;
        do_reset();
        wr_reg(32'h100A_9241);
        send(OP_ACT, 0, "R10", a);
        send(OP_WR, 0, "R10", w);
        first1 = -1; first2 = -1;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = OP_RD; cmd_bank = 3'd0;
        for (int k = 0; k < 30 && first2 < 0; k++) begin
            #1;
            if (cmd_ready && first1 < 0) first1 = cyc;
            if (cmd_ready2 && first2 < 0) first2 = cyc;
            @(negedge clk);
        end
        cmd_valid = 1'b0; cmd_op = OP_NOP;
        chk(first1 - w == 1, "R6 field spacing zero", first1 - w, 1);
        chk(first2 - w == 6, "R10 derived WR to RD spacing", first2 - w, 6);
        idle(20);
    endtask

    initial begin
        int dummy;
        do_reset();
        t_reset_state();
        t_always_ready();
        t_rcd();
        t_rp();
        t_rrd();
        t_rc();
        t_wtr();
        t_rfc();
        t_reg_write();
        t_zero_fields();
        t_derived();
        dummy = 0;
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

endmodule